// File: doc/BRIEF.md
# Base-2 Fixed-Point Cross-Entropy Loss Engine

This block turns one sample's vector of class scores into a single classification loss value. The scores arrive one per cycle on a valid-qualified stream, and the index of the correct class is given with the first score. The engine stores the vector and tracks its largest score while the vector arrives. It then makes a second pass over the stored scores. In that pass it raises two to each score minus the maximum and adds up the terms. A serial normaliser takes the base-2 logarithm of that sum. The loss is the maximum, plus that logarithm, minus the score of the target class.

All values are 16-bit two's-complement numbers with 7 fraction bits, so one step is 1/128 and the range is -256.0 to just under +256.0. The power of two is built from a fraction lookup and a right shift. The logarithm is built from a count of right shifts and a second fraction lookup. No floating point is used anywhere. While the engine works on a vector, a busy flag is high and any new scores are ignored. When the result is ready, a one-cycle strobe marks it.

Top module: `xent_loss_unit`

## Requirements
- R1: Scores are 16-bit two's complement with 7 fraction bits. One vector is exactly NUM_CLASSES (default 100) scores, indexed 0 upwards in arrival order. The target index is sampled only together with score 0, and its value on later scores of the same vector has no effect. Indices 0 and NUM_CLASSES-1 are both valid targets.
- R2: The loss equals max + log2(sum over i of 2^(s_i - max)) - s_target, in the same 7-fraction-bit format, within 4 LSB of the exact real value.
- R3: When all scores are equal, the loss is log2(NUM_CLASSES). For 100 classes this is 850 LSB (6.640625), within 1 LSB.
- R4: The loss is never negative. When the target holds the maximum score, the loss reduces to the logarithm term alone.
- R5: A loss that would exceed the largest positive code is clamped to 16'h7FFF.
- R6: busy goes high in the cycle after the last score of a vector is accepted. It stays high until the result strobe. score_valid pulses while busy is high are ignored.
- R7: loss_valid is high for exactly one cycle per vector. busy is low in that cycle, so the next vector may start at once.
- R8: During and right after reset, busy, loss_valid and loss_data are all 0.
- R9: A term whose exponent lies more than 16 octaves below the maximum contributes exactly zero. In that case, a lone maximum that is also the target gives a loss of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| score_valid | input | 1 | A score is present on score_data |
| score_data | input | 16 | Class score, signed, 7 fraction bits |
| target_idx | input | IDX_W (7) | Index of the correct class, sampled with score 0 |
| busy | output | 1 | Engine is processing a vector; input is ignored |
| loss_valid | output | 1 | One-cycle strobe: loss_data holds a new result |
| loss_data | output | 16 | Loss, signed format, never negative, clamped |

## Verification
Three situations are hard to reach from the ports. The first is a vector where nearly every term falls below the 16-bit fraction of the accumulator. The second is a loss large enough to clamp. The third is traffic that arrives while the engine is still busy. Vectors with one score at the top of the range and the rest at the bottom drive the exponent shifts past the fraction width, and a low-scored target on such a vector forces the clamp. One random vector is followed by random scores pushed for every busy cycle. Random target indices follow score 0 on every vector. The reported loss must still match the reference computed from the original vector and target.

// File: rtl/xent_pkg.sv
// Package for the cross-entropy loss engine.
// Holds the fixed number format, the controller state type and the
// elaboration-time functions that build both fraction lookup tables.
// Assumes a score fraction of 7 bits: the table step constant is 2^(1/128).
package xent_pkg;

    localparam int SCORE_W    = 16;   // score and loss word
    localparam int SCORE_FRAC = 7;    // fraction bits of score and loss
    localparam int EXP_FRAC   = 16;   // fraction bits of each power-of-two term
    localparam int Q_BITS     = 30;   // precision of table generation
    localparam int LUT_N      = 1 << SCORE_FRAC;

    // 2^(1/128) scaled by 2^30
    localparam longint unsigned STEP_Q = 64'd1079572136;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_EXP  = 2'd1,
        ST_LOG  = 2'd2
    } xent_state_e;

    // multiply a Q30 value by one table step, rounded
    function automatic longint unsigned q_step(input longint unsigned r);
        return (r * STEP_Q + (64'd1 << (Q_BITS - 1))) >> Q_BITS;
    endfunction

    // convert a Q30 value to EXP_FRAC fraction bits, rounded
    function automatic logic [EXP_FRAC:0] q_to_term(input longint unsigned r);
        return (EXP_FRAC + 1)'((r + (64'd1 << (Q_BITS - EXP_FRAC - 1))) >> (Q_BITS - EXP_FRAC));
    endfunction

    // 2^(k/128) with EXP_FRAC fraction bits, value in [1, 2)
    function automatic logic [EXP_FRAC:0] exp2_frac_entry(input int k);
        longint unsigned r;
        r = 64'd1 << Q_BITS;
        for (int i = 0; i < k; i++) r = q_step(r);
        return q_to_term(r);
    endfunction

    // round(128 * log2(1 + k/128)), saturated at 127, found by the
    // midpoint between neighbouring power-of-two table values
    function automatic logic [SCORE_FRAC-1:0] log2_frac_entry(input int k);
        longint unsigned r;
        longint unsigned twice_x;
        longint unsigned prev;
        longint unsigned cur;
        int              res;
        twice_x = 64'(LUT_N + k) << (EXP_FRAC - SCORE_FRAC + 1);
        r       = 64'd1 << Q_BITS;
        prev    = 64'(q_to_term(r));
        res     = 0;
        for (int j = 1; j < LUT_N; j++) begin
            r   = q_step(r);
            cur = 64'(q_to_term(r));
            if (twice_x >= prev + cur) res = j;
            prev = cur;
        end
        return SCORE_FRAC'(res);
    endfunction

endpackage

// File: rtl/xent_exp2_term.sv
// Power-of-two term generator (combinational).
// Input is d = max - score, which is never negative. Output is 2^(-d) with
// EXP_FRAC fraction bits, so the value lies in (0, 1]. With d = n + f/128:
// f = 0 gives 2^-n, otherwise 2^((128-f)/128) * 2^-(n+1).
// A shift larger than EXP_FRAC gives a zero term.
module xent_exp2_term
    import xent_pkg::*;
#(
    parameter int DIFF_W = SCORE_W + 1,
    parameter int TERM_W = EXP_FRAC + 1
) (
    input  logic [DIFF_W-1:0] diff,
    output logic [TERM_W-1:0] term
);

    localparam int INT_W = DIFF_W - SCORE_FRAC;
    localparam int SH_W  = INT_W + 1;

    logic [TERM_W-1:0]     pow_lut [LUT_N];
    logic [INT_W-1:0]      int_part;
    logic [SCORE_FRAC-1:0] frac_part;
    logic [SCORE_FRAC-1:0] lut_idx;
    logic [SH_W-1:0]       shamt;

    // table of 2^(k/128), built at elaboration
    for (genvar k = 0; k < LUT_N; k++) begin : g_pow
        localparam logic [TERM_W-1:0] ENTRY = TERM_W'(exp2_frac_entry(k));
        assign pow_lut[k] = ENTRY;
    end

    // split the distance into octaves and a complementary fraction
    always_comb begin
        int_part  = diff[DIFF_W-1:SCORE_FRAC];
        frac_part = diff[SCORE_FRAC-1:0];
        lut_idx   = SCORE_FRAC'(0) - frac_part;
        shamt     = SH_W'(int_part) + SH_W'(frac_part != '0);
    end

    // scale the mantissa down by the octave count, flush far terms to zero
    always_comb begin
        if (shamt > SH_W'(EXP_FRAC)) term = '0;
        else                          term = pow_lut[lut_idx] >> shamt;
    end

endmodule

// File: rtl/xent_log2_norm.sv
// Serial base-2 logarithm of the term sum.
// Assumes the sum is at least 1.0 (EXP_FRAC fraction bits), which holds
// because the maximum score always contributes exactly 1.0. Each cycle the
// sum shifts right by one while its integer part exceeds 1, and the number
// of shifts becomes the integer result. The top 7 fraction bits, rounded
// to nearest, then index a log2(1 + k/128) table for the result fraction.
module xent_log2_norm
    import xent_pkg::*;
#(
    parameter int ACC_W = EXP_FRAC + 8,
    parameter int INT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ACC_W-1:0]            sum_in,
    output logic                        done,
    output logic [INT_W+SCORE_FRAC-1:0] log_out
);

    localparam int SUM_INT_W = ACC_W - EXP_FRAC;
    localparam int TAIL_W    = EXP_FRAC - SCORE_FRAC;
    localparam int LOG_W     = INT_W + SCORE_FRAC;

    logic [SCORE_FRAC-1:0] frac_lut [LUT_N];
    logic [ACC_W-1:0]      sum_q;
    logic [INT_W-1:0]      cnt_q;
    logic                  run_q;
    logic                  done_q;
    logic [LOG_W-1:0]      res_q;

    logic [SUM_INT_W-1:0]  sum_int;
    logic [SCORE_FRAC-1:0] idx_base;
    logic [TAIL_W-1:0]     tail;
    logic                  round_up;
    logic [SCORE_FRAC-1:0] frac_idx;

    // table of round(128*log2(1+k/128)), built at elaboration
    for (genvar k = 0; k < LUT_N; k++) begin : g_log
        localparam logic [SCORE_FRAC-1:0] ENTRY = log2_frac_entry(k);
        assign frac_lut[k] = ENTRY;
    end

    // pick the fraction index with round-to-nearest, saturating at the top
    always_comb begin
        sum_int  = sum_q[ACC_W-1:EXP_FRAC];
        idx_base = sum_q[EXP_FRAC-1 -: SCORE_FRAC];
        tail     = sum_q[TAIL_W-1:0];
        round_up = tail >= TAIL_W'(1 << (TAIL_W - 1));
        frac_idx = (&idx_base) ? idx_base : idx_base + SCORE_FRAC'(round_up);
    end

    // normalise the sum one octave per cycle and latch the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else if (start) begin
            sum_q  <= sum_in;
            cnt_q  <= '0;
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (run_q) begin
            if (sum_int > SUM_INT_W'(1)) begin
                sum_q <= sum_q >> 1;
                cnt_q <= cnt_q + INT_W'(1);
            end else begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
                res_q  <= {cnt_q, frac_lut[frac_idx]};
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done    = done_q;
    assign log_out = res_q;

    // R2
    norm_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (sum_int == SUM_INT_W'(1)));

    // R2
    sum_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (sum_int != '0));

endmodule

// File: rtl/xent_loss_unit.sv
// Cross-entropy loss engine, top level.
// Pass one stores NUM_CLASSES scores, tracks the signed maximum and keeps
// the target score. The target index is taken with score 0. Pass two reads
// the buffer once and adds 2^(score - max) into an accumulator. A serial
// log2 unit then normalises the sum, and the loss is max + log2(sum) - target,
// clamped to the 16-bit range. Assumes target_idx < NUM_CLASSES.
module xent_loss_unit
    import xent_pkg::*;
#(
    parameter int NUM_CLASSES = 100,
    parameter int IDX_W       = $clog2(NUM_CLASSES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               score_valid,
    input  logic [SCORE_W-1:0] score_data,
    input  logic [IDX_W-1:0]   target_idx,
    output logic               busy,
    output logic               loss_valid,
    output logic [SCORE_W-1:0] loss_data
);

    localparam int ACC_W     = EXP_FRAC + 1 + $clog2(NUM_CLASSES);
    localparam int LOG_INT_W = $clog2(ACC_W - EXP_FRAC);
    localparam int LOG_W     = LOG_INT_W + SCORE_FRAC;
    localparam int DIFF_W    = SCORE_W + 1;
    localparam int TERM_W    = EXP_FRAC + 1;
    localparam int WIDE_W    = SCORE_W + 3;
    localparam logic [IDX_W-1:0]         LAST_IDX = IDX_W'(NUM_CLASSES - 1);
    localparam logic [TERM_W-1:0]        TERM_ONE = TERM_W'(1) << EXP_FRAC;
    localparam logic signed [WIDE_W-1:0] SAT_HI   = WIDE_W'((1 << (SCORE_W - 1)) - 1);

    xent_state_e               state_q;
    logic [IDX_W-1:0]          cnt_q;
    logic [IDX_W-1:0]          tgt_idx_q;
    logic signed [SCORE_W-1:0] max_q;
    logic signed [SCORE_W-1:0] tgt_score_q;
    logic [ACC_W-1:0]          acc_q;
    logic                      valid_q;
    logic [SCORE_W-1:0]        loss_q;
    logic signed [SCORE_W-1:0] buf_q [NUM_CLASSES];

    logic                      accept;
    logic                      last_slot;
    logic [IDX_W-1:0]          tgt_sel;
    logic signed [SCORE_W-1:0] in_score;
    logic signed [SCORE_W-1:0] rd_score;
    logic [DIFF_W-1:0]         diff;
    logic [TERM_W-1:0]         term;
    logic                      log_start;
    logic [ACC_W-1:0]          log_sum;
    logic                      log_done;
    logic [LOG_W-1:0]          log_val;
    logic signed [WIDE_W-1:0]  loss_wide;
    logic [SCORE_W-1:0]        loss_sat;

    // decode input acceptance and the current target slot
    always_comb begin
        accept    = (state_q == ST_LOAD) && score_valid;
        last_slot = (cnt_q == LAST_IDX);
        tgt_sel   = (cnt_q == '0) ? target_idx : tgt_idx_q;
        in_score  = $signed(score_data);
        rd_score  = buf_q[cnt_q];
        diff      = DIFF_W'(max_q) - DIFF_W'(rd_score);
        log_start = (state_q == ST_EXP) && last_slot;
        log_sum   = acc_q + ACC_W'(term);
    end

    // score buffer written during the load pass
    always_ff @(posedge clk) begin
        if (accept) buf_q[cnt_q] <= in_score;
    end

    // controller: load pass, exponent pass, wait for the logarithm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_LOAD;
            cnt_q       <= '0;
            tgt_idx_q   <= '0;
            max_q       <= '0;
            tgt_score_q <= '0;
            acc_q       <= '0;
        end else begin
            case (state_q)
                ST_LOAD: begin
                    if (accept) begin
                        if (cnt_q == '0) tgt_idx_q <= target_idx;
                        if (cnt_q == '0 || in_score > max_q) max_q <= in_score;
                        if (cnt_q == tgt_sel) tgt_score_q <= in_score;
                        if (last_slot) begin
                            cnt_q   <= '0;
                            acc_q   <= '0;
                            state_q <= ST_EXP;
                        end else begin
                            cnt_q <= cnt_q + IDX_W'(1);
                        end
                    end
                end
                ST_EXP: begin
                    acc_q <= log_sum;
                    if (last_slot) begin
                        cnt_q   <= '0;
                        state_q <= ST_LOG;
                    end else begin
                        cnt_q <= cnt_q + IDX_W'(1);
                    end
                end
                ST_LOG: begin
                    if (log_done) state_q <= ST_LOAD;
                end
                default: state_q <= ST_LOAD;
            endcase
        end
    end

    xent_exp2_term #(
        .DIFF_W (DIFF_W),
        .TERM_W (TERM_W)
    ) u_exp (
        .diff (diff),
        .term (term)
    );

    xent_log2_norm #(
        .ACC_W (ACC_W),
        .INT_W (LOG_INT_W)
    ) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (log_start),
        .sum_in  (log_sum),
        .done    (log_done),
        .log_out (log_val)
    );

    // combine max, logarithm and target score, clamp to the word range
    always_comb begin
        loss_wide = WIDE_W'(max_q) + $signed({{(WIDE_W - LOG_W){1'b0}}, log_val})
                  - WIDE_W'(tgt_score_q);
        if (loss_wide > SAT_HI)       loss_sat = {1'b0, {(SCORE_W - 1){1'b1}}};
        else if (loss_wide[WIDE_W-1]) loss_sat = '0;
        else                          loss_sat = loss_wide[SCORE_W-1:0];
    end

    // result register and one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            loss_q  <= '0;
        end else begin
            valid_q <= log_done;
            if (log_done) loss_q <= loss_sat;
        end
    end

    assign busy       = (state_q != ST_LOAD);
    assign loss_valid = valid_q;
    assign loss_data  = loss_q;

    // R7
    loss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R7
    ready_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !busy);

    // R6
    busy_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_slot) |=> busy);

    // R6
    max_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(max_q));

    // R4
    loss_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !loss_q[SCORE_W-1]);

    // R2
    max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXP) |-> (max_q >= rd_score));

    // R2
    term_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXP) |-> (term <= TERM_ONE));

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

endmodule

// File: tb/xent_loss_unit_bench.sv
module xent_loss_unit_bench;

    localparam int N = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        score_valid = 1'b0;
    logic [15:0] score_data = '0;
    logic [6:0]  target_idx = '0;
    wire         busy;
    wire         loss_valid;
    wire  [15:0] loss_data;

    int vec [N];
    int q_exp [$];
    int q_tol [$];
    int q_req [$];
    int n_checks = 0;
    int n_fail   = 0;
    bit prev_valid = 1'b0;

    always #5 clk = ~clk;

    xent_loss_unit u_xent_loss_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .score_valid (score_valid),
        .score_data  (score_data),
        .target_idx  (target_idx),
        .busy        (busy),
        .loss_valid  (loss_valid),
        .loss_data   (loss_data)
    );

    task automatic check(input int req, input int act, input int expv, input int tol);
        n_checks++;
        if (act > expv + tol || act < expv - tol) begin
            n_fail++;
            $display("FAIL R%0d: actual %0d expected %0d (tol %0d)", req, act, expv, tol);
        end
    endtask

    // real-valued base-2 reference loss in LSB units
    function automatic int ref_loss(input int tgt);
        real m, s, l;
        m = vec[0];
        for (int i = 1; i < N; i++) if (vec[i] > m) m = vec[i];
        s = 0.0;
        for (int i = 0; i < N; i++) s = s + $pow(2.0, (vec[i] - m) / 128.0);
        l = (m - vec[tgt]) + 128.0 * $ln(s) / $ln(2.0);
        if (l > 32767.0) return 32767;
        return int'($floor(l + 0.5));
    endfunction

    task automatic fill_random(input int lo, input int hi);
        for (int i = 0; i < N; i++) vec[i] = int'($urandom_range(32'(hi - lo))) + lo;
    endtask

    task automatic fill_const(input int v);
        for (int i = 0; i < N; i++) vec[i] = v;
    endtask

    // driver: push expected result, then stream the vector
    task automatic run_vector(input int tgt, input int req, input int tol, input bit junk);
        q_exp.push_back(ref_loss(tgt));
        q_tol.push_back(tol);
        q_req.push_back(req);
        @(negedge clk);
        while (busy) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            score_valid = 1'b1;
            score_data  = 16'(vec[i]);
            // R1: index only counts with score 0
            target_idx  = (i == 0) ? 7'(tgt) : 7'($urandom_range(N - 1));
            @(negedge clk);
        end
        score_valid = 1'b0;
        check(6, int'(busy), 1, 0); // R6 busy after last score
        if (junk) begin
            while (busy) begin
                score_valid = 1'b1; // R6 ignored while busy
                score_data  = 16'($urandom);
                @(negedge clk);
            end
            score_valid = 1'b0;
        end
    endtask

    // monitor: pop and compare on each result strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check(7, int'(loss_valid), 0, 0); // R7 one cycle
            if (loss_valid) begin
                check(7, int'(busy), 0, 0); // R7 ready with result
                if (q_exp.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R7: actual unexpected strobe expected none");
                end else begin
                    check(q_req.pop_front(), int'($signed(loss_data)),
                          q_exp.pop_front(), q_tol.pop_front());
                end
            end
            prev_valid = loss_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R6: actual hung (busy=%0d) expected completion", busy);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(8, int'(busy), 0, 0);
        check(8, int'(loss_valid), 0, 0);
        check(8, int'(loss_data), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 equal scores: log2(100) = 850 LSB
        fill_const(640);
        run_vector(17, 3, 1, 1'b0);
        fill_const(-3000);
        run_vector(99, 3, 1, 1'b0);

        // R4 target holds the maximum
        fill_random(-6000, 6000);
        vec[42] = 20000;
        run_vector(42, 4, 4, 1'b0);

        // R1 boundary target indices 0 and 99
        fill_random(-2000, 2000);
        run_vector(0, 1, 4, 1'b0);
        fill_random(-2000, 2000);
        run_vector(99, 1, 4, 1'b0);

        // R9 far terms vanish: lone maximum as target gives exactly 0
        fill_const(-32768);
        vec[3] = 32767;
        run_vector(3, 9, 0, 1'b0);

        // R5 clamp: lone maximum, target at the bottom
        run_vector(50, 5, 0, 1'b0);

        // R6 scores pushed while busy are ignored
        fill_random(-8000, 8000);
        run_vector(23, 6, 4, 1'b1);

        // R2 narrow range exercising the fraction tables
        for (int t = 0; t < 5; t++) begin
            fill_random(-200, 200);
            run_vector(int'($urandom_range(N - 1)), 2, 4, 1'b0);
        end

        // R2 full-range random vectors
        for (int t = 0; t < 15; t++) begin
            fill_random(-32768, 32767);
            run_vector(int'($urandom_range(N - 1)), 2, 4, 1'b0);
        end

        while (q_exp.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule